// File: doc/BRIEF.md
# Carrier Chopper with Leading One-Shot

This block chops a slow PWM level with a high-frequency carrier so that the gate drive can cross an isolation transformer, which passes only alternating signals. Each time the PWM input goes high, the output first holds high for one long pulse. This pulse gives the switch a strong turn-on. After it, the output becomes a train of short sustaining pulses at the carrier rate, and each pulse has a programmable high fraction.

A prescaler divides the module clock by `prescale+1` to form the carrier tick. Eight ticks make one carrier period. The duty value states how many of those eighths are high. The one-shot lasts `shotWidth+1` whole carrier periods. The carrier phase restarts at every rising edge of the PWM input. When the input goes low, the output is low at once. With the enable low, the input passes straight to the output.

Top module: `pwm_chopper`

## Requirements
- R1: When `enable` is 0, `chopOut` equals `pwmIn` in the same cycle, whatever the counters hold.
- R2: When `enable` is 1 and `pwmIn` is 0, `chopOut` is 0.
- R3: Count the first cycle in which `pwmIn` is seen high as cycle k=0. From k=0, `chopOut` is 1 for exactly N = 8·(prescale+1)·(shotWidth+1) consecutive cycles, as long as `pwmIn` stays high.
- R4: From cycle k ≥ N, the carrier phase is ph = (k / (prescale+1)) mod 8. `chopOut` is 1 exactly when ph < duty, so the high time per carrier period is duty/8.
- R5: A `duty` value of 0 behaves exactly like a value of 1, which gives a 1/8 high time.
- R6: A falling edge on `pwmIn` drives `chopOut` low in that same cycle and abandons any one-shot in progress. The next rising edge starts a complete new one-shot at k=0.
- R7: The prescaler stretches each eighth of a carrier period to `prescale+1` clock cycles. With prescale 0, one carrier period is 8 cycles.
- R8: `shotWidth` is 4 bits. Its values 0 and 15 give one-shot lengths of 1 and 16 carrier periods.
- R9: If `enable` rises while `pwmIn` is already high, the cycle in which enable is first seen high is k=0 of a fresh one-shot.
- R10: While the output is in the sustaining phase, it is low in carrier phase 7 for every duty setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwmIn | input | 1 | PWM level to be chopped |
| enable | input | 1 | 1 = chopping active, 0 = pass-through |
| prescale | input | PRE_W | Carrier tick divider minus one |
| shotWidth | input | WID_W | One-shot length in carrier periods minus one |
| duty | input | 3 | Sustaining high time in eighths (0 treated as 1) |
| chopOut | output | 1 | Chopped drive output |

## Verification
The output is a combinational product of the inputs and the registered counters, so any input change shows on `chopOut` in the same cycle. The counters then advance at the next rising edge. The bench changes inputs on the falling edge, samples one nanosecond later, and numbers the sample cycles k from the first sample that sees the new input level. This is how R3, R4 and R9 are written. Each expected value comes from the closed-form N and phase formulas, computed for that k.

// File: rtl/chopper_pkg.sv
package chopper_pkg;
  typedef enum logic [1:0] {
    CH_IDLE    = 2'd0,
    CH_SHOT    = 2'd1,
    CH_SUSTAIN = 2'd2
  } chopState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;     // drop all counters to zero
    logic run;       // advance the carrier counters
    logic shotPhase; // output held high, periods being counted
  } chopStrobe_t;
endpackage

// File: rtl/chop_ctrl.sv
module chop_ctrl
  import chopper_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pwmIn,
  input  logic        enable,
  input  logic        shotEnd,
  output chopStrobe_t strobe,
  output logic        inSustain
);
  chopState_t state, stateNext;
  logic active;

  assign active = pwmIn & enable;

  always_comb begin
    stateNext = state;
    if (!active) begin
      stateNext = CH_IDLE;
    end else begin
      case (state)
        CH_IDLE:    stateNext = CH_SHOT;
        CH_SHOT:    stateNext = shotEnd ? CH_SUSTAIN : CH_SHOT;
        CH_SUSTAIN: stateNext = CH_SUSTAIN;
        default:    stateNext = CH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= CH_IDLE;
    else        state <= stateNext;
  end

  always_comb begin
    strobe.clear     = !active;
    strobe.run       = active;
    strobe.shotPhase = (state != CH_SUSTAIN);
  end

  assign inSustain = (state == CH_SUSTAIN);
endmodule

// File: rtl/chop_datapath.sv
module chop_datapath
  import chopper_pkg::*;
#(
  parameter int PRE_W   = 8,
  parameter int WID_W   = 4,
  parameter int EIGHTHS = 8,
  localparam int PH_W   = $clog2(EIGHTHS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  chopStrobe_t      strobe,
  input  logic             pwmIn,
  input  logic             enable,
  input  logic [PRE_W-1:0] prescale,
  input  logic [WID_W-1:0] shotWidth,
  input  logic [PH_W-1:0]  duty,
  output logic             shotEnd,
  output logic [PH_W-1:0]  phase,
  output logic             chopOut
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(EIGHTHS - 1);

  logic [PRE_W-1:0] preCnt;
  logic [WID_W-1:0] perCnt;
  logic [PH_W-1:0]  dutyEff;
  logic             tick, periodEnd, carrierHigh;

  assign tick      = (preCnt == prescale);
  assign periodEnd = tick && (phase == LAST_PH);
  assign shotEnd   = periodEnd && (perCnt == shotWidth);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preCnt <= '0;
      phase  <= '0;
      perCnt <= '0;
    end else if (strobe.clear) begin
      preCnt <= '0;
      phase  <= '0;
      perCnt <= '0;
    end else if (strobe.run) begin
      preCnt <= tick ? '0 : preCnt + 1'b1;
      if (tick) phase <= (phase == LAST_PH) ? '0 : phase + 1'b1;
      if (periodEnd && strobe.shotPhase) perCnt <= perCnt + 1'b1;
    end
  end

  assign dutyEff     = (duty == '0) ? PH_W'(1) : duty;
  assign carrierHigh = (phase < dutyEff);

  always_comb begin
    if (!enable) chopOut = pwmIn;
    else         chopOut = pwmIn & (strobe.shotPhase | carrierHigh);
  end
endmodule

// File: rtl/pwm_chopper.sv
module pwm_chopper
  import chopper_pkg::*;
#(
  parameter int PRE_W   = 8,
  parameter int WID_W   = 4,
  parameter int EIGHTHS = 8,
  localparam int PH_W   = $clog2(EIGHTHS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwmIn,
  input  logic             enable,
  input  logic [PRE_W-1:0] prescale,
  input  logic [WID_W-1:0] shotWidth,
  input  logic [PH_W-1:0]  duty,
  output logic             chopOut
);
  chopStrobe_t strobe;
  logic        shotEnd;
  logic        sustNow;
  logic [PH_W-1:0] phaseNow;

  chop_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwmIn    (pwmIn),
    .enable   (enable),
    .shotEnd  (shotEnd),
    .strobe   (strobe),
    .inSustain(sustNow)
  );

  chop_datapath #(
    .PRE_W  (PRE_W),
    .WID_W  (WID_W),
    .EIGHTHS(EIGHTHS)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .pwmIn    (pwmIn),
    .enable   (enable),
    .prescale (prescale),
    .shotWidth(shotWidth),
    .duty     (duty),
    .shotEnd  (shotEnd),
    .phase    (phaseNow),
    .chopOut  (chopOut)
  );
endmodule

// File: rtl/chop_checker.sv
module chop_checker #(
  parameter int PH_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pwmIn,
  input logic            enable,
  input logic            chopOut,
  input logic            sustNow,
  input logic [PH_W-1:0] phaseNow
);
  // R1: bypass while disabled
  a_r1_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (chopOut == pwmIn));

  // R2: low input gives low output
  a_r2_low_in_low_out: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !pwmIn) |-> !chopOut);

  // R3: the first high cycle of the input opens the one-shot
  a_r3_shot_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && pwmIn && !$past(pwmIn)) |-> chopOut);

  // R10: the last eighth of a sustaining period is always low
  a_r10_last_eighth_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sustNow && (phaseNow == {PH_W{1'b1}})) |-> !chopOut);

  // R6: input fall ends the sustaining phase by the next cycle
  a_r6_fall_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $fell(pwmIn)) |=> !sustNow);
endmodule

bind pwm_chopper chop_checker #(.PH_W(PH_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .pwmIn   (pwmIn),
  .enable  (enable),
  .chopOut (chopOut),
  .sustNow (sustNow),
  .phaseNow(phaseNow)
);

// File: tb/pwm_chopper_bench.sv
module pwm_chopper_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       pwmIn = 0;
  logic       enable = 0;
  logic [7:0] prescale = '0;
  logic [3:0] shotWidth = '0;
  logic [2:0] duty = '0;
  logic       chopOut;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwm_chopper u_pwm_chopper (
    .clk(clk), .rst_n(rst_n), .pwmIn(pwmIn), .enable(enable),
    .prescale(prescale), .shotWidth(shotWidth), .duty(duty), .chopOut(chopOut)
  );

  function automatic bit model(int k, int p, int w, int d);
    int n, ph, de;
    n  = 8 * (p + 1) * (w + 1);
    if (k < n) return 1'b1;
    ph = (k / (p + 1)) % 8;
    de = (d == 0) ? 1 : d;
    return ph < de;
  endfunction

  task automatic check(bit act, bit exp, string req, int k);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s k=%0d actual=%0b expected=%0b", req, k, act, exp);
    end
  endtask

  // drive at negedge, sample 1 ns later
  task automatic step();
    @(negedge clk);
  endtask

  task automatic burst(int p, int w, int d, int len, string req);
    prescale = 8'(p); shotWidth = 4'(w); duty = 3'(d); enable = 1;
    step(); pwmIn = 1;
    for (int k = 0; k < len; k++) begin
      #1 check(chopOut, model(k, p, w, d), req, k);
      step();
    end
    pwmIn = 0;
    #1 check(chopOut, 1'b0, "R2", -1);
    step(); step();
  endtask

  task automatic testReset();
    enable = 1;
    #1 check(chopOut, 1'b0, "R2 reset", 0);
    step(); rst_n = 1;
    step();
    #1 check(chopOut, 1'b0, "R2 after reset", 0);
  endtask

  task automatic testBypass();
    enable = 0; prescale = 8'd3; duty = 3'd2;
    for (int k = 0; k < 40; k++) begin
      step(); pwmIn = ((k % 7) < 3);
      #1 check(chopOut, pwmIn, "R1", k);
    end
    step(); pwmIn = 0; step();
  endtask

  task automatic testAbort();
    prescale = 8'd1; shotWidth = 4'd2; duty = 3'd4; enable = 1;
    step(); pwmIn = 1;
    for (int k = 0; k < 20; k++) begin
      #1 check(chopOut, model(k, 1, 2, 4), "R3", k);
      step();
    end
    pwmIn = 0;
    #1 check(chopOut, 1'b0, "R6 fall", 0);
    step(); pwmIn = 1;
    for (int k = 0; k < 70; k++) begin
      #1 check(chopOut, model(k, 1, 2, 4), "R6 restart", k);
      step();
    end
    pwmIn = 0; step(); step();
  endtask

  task automatic testLateEnable();
    prescale = 8'd0; shotWidth = 4'd1; duty = 3'd6; enable = 0;
    step(); pwmIn = 1;
    for (int k = 0; k < 11; k++) begin
      #1 check(chopOut, 1'b1, "R1 high", k);
      step();
    end
    enable = 1;
    for (int k = 0; k < 40; k++) begin
      #1 check(chopOut, model(k, 0, 1, 6), "R9", k);
      step();
    end
    pwmIn = 0; step(); step();
  endtask

  initial begin
    testReset();
    burst(0, 0, 3, 40, "R4");
    burst(2, 1, 5, 110, "R7");
    burst(1, 0, 0, 48, "R5");
    burst(0, 0, 1, 32, "R5 ref");
    burst(0, 15, 7, 150, "R8 max");
    burst(3, 0, 7, 70, "R10");
    testAbort();
    testBypass();
    testLateEnable();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule